// File: doc/BRIEF.md
# Interface PHY Power Sequencer

This controller turns the supply controls of five chip interfaces on and off: two display serial links, one camera-transmit link, a USB PHY and an HDMI PHY. A requester presents a one-hot interface select, an on/off direction and a pulse on `req_valid`. The block then writes that interface's control word in a fixed order, one write per clock. For the HDMI power-up it also holds a reset-drive bit through a timed settle window before it releases it.

The settle window is counted in microseconds. A prescaler built from the `CYC_PER_US` parameter turns clock cycles into microseconds, and the `settle_us` port sets the number of microseconds. When a sequence ends, `done` pulses for one cycle. A select that names no interface, or names more than one, is refused: `err` pulses and nothing is written. A read port returns any control word so that its state can be observed.

Select and read-index encoding is the same for both: index 0 = display link A, 1 = display link B, 2 = camera transmit, 3 = USB, 4 = HDMI. Select bits 5 to 7 name no interface.

Top module: `pwrseq_phy_power`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low. Every control word reads 0x00000 except HDMI, which reads 0x00002 (LDO power-down, bit 1, set).
- R2: Display link power-on writes 0x1 (control enable, bit 0), then 0x5 (adds high-power LDO enable, bit 2). Bit 1 is the low-power LDO enable and stays clear. Bit 2 is never set while bit 0 is clear.
- R3: Display link power-off writes 0x1, then 0x0.
- R4: Camera-transmit power-on writes 0x1, then 0x3 (LDO enable, bit 1). Its power-off writes 0x1, then 0x0.
- R5: USB power-on is a single write of 0x1 and power-off a single write of 0x0. No bit above bit 0 is ever set.
- R6: HDMI power-on performs four read-modify-writes in this order: set bit 19 (reset drive), set bit 0, clear bit 1, and after the settle window clear bit 19. Bit 19 is set and bit 1 clear for the whole window.
- R7: HDMI power-off sets bit 1, then clears bit 0.
- R8: The settle window lasts max(`settle_us`,1) × `CYC_PER_US` cycles. The bit-19 release appears that many cycles plus one after the bit-1 clear. `settle_us` is sampled when the request is accepted.
- R9: `done` is high for exactly one cycle, the cycle in which the final written value is first visible, and `busy` is low in that cycle.
- R10: A request whose select is zero, has more than one bit set, or sets only bits 5 to 7 raises `err` for one cycle, in the cycle after it is presented. It writes no control word and `busy` stays low.
- R11: A request presented while `busy` is high is ignored and writes no control word.
- R12: A read index of 5, 6 or 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_sel | input | SEL_W | One-hot interface select |
| req_on | input | 1 | 1 = power on, 0 = power off |
| settle_us | input | US_W | HDMI settle window in microseconds |
| rd_idx | input | 3 | Control word read index |
| rd_data | output | 20 | Selected control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle sequence-complete pulse |
| err | output | 1 | One-cycle invalid-request pulse |

## Verification
Every on and off sequence is run from a state where each write changes the word. A monitor therefore sees every intermediate value and tells a reordered or missing step apart from a wrong final value. HDMI power-up is run with a non-zero window and with a zero window, which separates the prescaler product from the clamp to one microsecond. Zero, multi-bit and undefined-bit selects each test a different branch of the validity decode. A request injected mid-sequence shows whether the idle gating holds.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NUM_IF    = 5;
  localparam int REG_W     = 20;
  localparam int IF_IDX_W  = 3;

  localparam int IF_DISP_A = 0;
  localparam int IF_DISP_B = 1;
  localparam int IF_CAMTX  = 2;
  localparam int IF_USB    = 3;
  localparam int IF_HDMI   = 4;

  localparam int BIT_EN      = 0;
  localparam int BIT_LDO     = 1;   // camera-transmit LDO enable
  localparam int BIT_LDO_HP  = 2;   // display high-power LDO enable
  localparam int BIT_HDMI_PD = 1;   // HDMI LDO power-down
  localparam int BIT_HDMI_RD = 19;  // HDMI reset drive

  typedef logic [REG_W-1:0]    word_t;
  typedef logic [IF_IDX_W-1:0] if_idx_t;
  typedef enum logic [1:0] {OP_SET, OP_CLR, OP_LOAD} op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    word_t    mask;
    logic     hold;   // start settle window after this write
    logic     last;   // final write of the sequence
  } op_t;

  function automatic word_t bitw(input int b);
    return word_t'(1) << b;
  endfunction

  function automatic word_t reset_word(input int i);
    return (i == IF_HDMI) ? bitw(BIT_HDMI_PD) : '0;
  endfunction

  function automatic op_t mk(input op_kind_e k, input word_t m, input logic h, input logic l);
    op_t o;
    o.kind = k; o.mask = m; o.hold = h; o.last = l;
    return o;
  endfunction

  // Ordered write program for each interface and direction.
  function automatic op_t step_op(input if_idx_t ifx, input logic on, input logic [2:0] step);
    op_t o;
    o = mk(OP_SET, '0, 1'b0, 1'b1);
    case (int'(ifx))
      IF_DISP_A, IF_DISP_B: begin
        if (step == 3'd0) o = mk(OP_LOAD, bitw(BIT_EN), 1'b0, 1'b0);
        else if (on)      o = mk(OP_LOAD, bitw(BIT_EN) | bitw(BIT_LDO_HP), 1'b0, 1'b1);
        else              o = mk(OP_LOAD, '0, 1'b0, 1'b1);
      end
      IF_CAMTX: begin
        if (step == 3'd0) o = mk(OP_LOAD, bitw(BIT_EN), 1'b0, 1'b0);
        else if (on)      o = mk(OP_LOAD, bitw(BIT_EN) | bitw(BIT_LDO), 1'b0, 1'b1);
        else              o = mk(OP_LOAD, '0, 1'b0, 1'b1);
      end
      IF_USB: o = mk(OP_LOAD, on ? bitw(BIT_EN) : '0, 1'b0, 1'b1);
      IF_HDMI: begin
        if (on) begin
          case (step)
            3'd0:    o = mk(OP_SET, bitw(BIT_HDMI_RD), 1'b0, 1'b0);
            3'd1:    o = mk(OP_SET, bitw(BIT_EN), 1'b0, 1'b0);
            3'd2:    o = mk(OP_CLR, bitw(BIT_HDMI_PD), 1'b1, 1'b0);
            default: o = mk(OP_CLR, bitw(BIT_HDMI_RD), 1'b0, 1'b1);
          endcase
        end else begin
          if (step == 3'd0) o = mk(OP_SET, bitw(BIT_HDMI_PD), 1'b0, 1'b0);
          else              o = mk(OP_CLR, bitw(BIT_EN), 1'b0, 1'b1);
        end
      end
      default: o = mk(OP_SET, '0, 1'b0, 1'b1);
    endcase
    return o;
  endfunction

  function automatic word_t apply_op(input word_t cur, input op_t o);
    case (o.kind)
      OP_SET:  return cur | o.mask;
      OP_CLR:  return cur & ~o.mask;
      default: return o.mask;
    endcase
  endfunction

  function automatic int unsigned settle_cycles(input int unsigned us, input int unsigned cyc);
    return ((us == 0) ? 1 : us) * cyc;
  endfunction
endpackage

// File: rtl/pwrseq_decode.sv
module pwrseq_decode
  import pwrseq_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  output if_idx_t          idx,
  output logic             ok
);
  localparam logic [SEL_W-1:0] DEF_MASK = SEL_W'((1 << NUM_IF) - 1);

  always_comb begin
    idx = '0;
    for (int i = 0; i < SEL_W; i++)
      if (sel[i]) idx = if_idx_t'(i);
    ok = $onehot(sel) && ((sel & DEF_MASK) != '0);
  end
endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] us_in,
  output logic            active,
  output logic            expire
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_left_q;

  assign expire = active && (pre_q == '0) && (us_left_q == US_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pre_q     <= '0;
      us_left_q <= '0;
    end else if (start) begin
      active    <= 1'b1;
      pre_q     <= PRE_TOP;
      us_left_q <= (us_in == '0) ? US_W'(1) : us_in;
    end else if (active) begin
      if (pre_q != '0) begin
        pre_q <= pre_q - 1'b1;
      end else if (us_left_q == US_W'(1)) begin
        active <= 1'b0;
      end else begin
        us_left_q <= us_left_q - 1'b1;
        pre_q     <= PRE_TOP;
      end
    end
  end
endmodule

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  if_idx_t widx,
  input  word_t   wdata,
  output word_t   words [NUM_IF]
);
  for (genvar g = 0; g < NUM_IF; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         words[g] <= reset_word(g);
      else if (we && widx == if_idx_t'(g)) words[g] <= wdata;
    end
  end
endmodule

// File: rtl/pwrseq_phy_power.sv
module pwrseq_phy_power
  import pwrseq_pkg::*;
#(
  parameter int SEL_W      = 8,
  parameter int US_W       = 8,
  parameter int CYC_PER_US = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic                req_on,
  input  logic [US_W-1:0]     settle_us,
  input  logic [IF_IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0]    rd_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WAIT} state_e;

  state_e          state_q;
  if_idx_t         cur_idx_q;
  logic            cur_on_q;
  logic [2:0]      step_q;
  logic [US_W-1:0] settle_q;

  if_idx_t dec_idx;
  logic    dec_ok;
  word_t   words [NUM_IF];
  word_t   cur_word, wr_data;
  op_t     cur_op;

  // named internal events
  logic accept, reject, wr_en, delay_start, delay_active, delay_expire, seq_end;
  word_t hdmi_word, usb_word, dispa_word;

  pwrseq_decode #(.SEL_W(SEL_W)) u_dec (.sel(req_sel), .idx(dec_idx), .ok(dec_ok));

  pwrseq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(cur_idx_q), .wdata(wr_data), .words(words)
  );

  pwrseq_delay #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .start(delay_start), .us_in(settle_q),
    .active(delay_active), .expire(delay_expire)
  );

  always_comb begin
    cur_word = '0;
    rd_data  = '0;
    for (int i = 0; i < NUM_IF; i++) begin
      if (cur_idx_q == if_idx_t'(i)) cur_word = words[i];
      if (rd_idx == if_idx_t'(i))    rd_data  = words[i];
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign accept      = (state_q == ST_IDLE) && req_valid && dec_ok;
  assign reject      = (state_q == ST_IDLE) && req_valid && !dec_ok;
  assign cur_op      = step_op(cur_idx_q, cur_on_q, step_q);
  assign wr_en       = (state_q == ST_WRITE);
  assign wr_data     = apply_op(cur_word, cur_op);
  assign delay_start = wr_en && cur_op.hold;
  assign seq_end     = wr_en && cur_op.last;
  assign hdmi_word   = words[IF_HDMI];
  assign usb_word    = words[IF_USB];
  assign dispa_word  = words[IF_DISP_A];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_idx_q <= '0;
      cur_on_q  <= 1'b0;
      step_q    <= '0;
      settle_q  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= seq_end;
      err  <= reject;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_WRITE;
          cur_idx_q <= dec_idx;
          cur_on_q  <= req_on;
          step_q    <= '0;
          settle_q  <= settle_us;
        end
        ST_WRITE: begin
          step_q <= step_q + 1'b1;
          if (cur_op.last)      state_q <= ST_IDLE;
          else if (cur_op.hold) state_q <= ST_WAIT;
        end
        ST_WAIT: if (delay_expire) state_q <= ST_WRITE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwrseq_phy_power_chk.sv
module pwrseq_phy_power_chk
  import pwrseq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            wr_en,
  input logic            reject,
  input logic            delay_start,
  input logic            delay_active,
  input logic [US_W-1:0] settle_q,
  input word_t           hdmi_word,
  input word_t           usb_word,
  input word_t           dispa_word
);
  logic [31:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win_cnt <= '0;
    else if (delay_start)  win_cnt <= '0;
    else if (delay_active) win_cnt <= win_cnt + 1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_idle_R9:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !busy && !wr_en));
  assert_hold_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    delay_active |-> (hdmi_word[BIT_HDMI_RD] && !hdmi_word[BIT_HDMI_PD]));
  assert_usb_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    usb_word[REG_W-1:1] == '0);
  assert_ldo_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dispa_word[BIT_LDO_HP] |-> dispa_word[BIT_EN]);
  assert_settle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(delay_active) |-> (win_cnt == settle_cycles(int'(settle_q), CYC_PER_US)));
endmodule

bind pwrseq_phy_power pwrseq_phy_power_chk #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .wr_en(wr_en),
  .reject(reject), .delay_start(delay_start), .delay_active(delay_active),
  .settle_q(settle_q), .hdmi_word(hdmi_word), .usb_word(usb_word), .dispa_word(dispa_word)
);

// File: tb/pwrseq_phy_power_test.sv
module pwrseq_phy_power_test;
  localparam int CPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_sel = '0;
  logic        req_on = 1'b0;
  logic [7:0]  settle_us = '0;
  logic [2:0]  rd_idx = '0;
  logic [19:0] rd_data;
  logic        busy, done, err;

  int checks = 0, errors = 0, cyc = 0;
  logic [19:0] mdl [5];
  logic [19:0] exp_q [$];
  int          chg_t [$];
  logic [19:0] mon_last;
  logic        mon_on = 1'b0;

  pwrseq_phy_power #(.SEL_W(8), .US_W(8), .CYC_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel), .req_on(req_on),
    .settle_us(settle_us), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  // monitor: every change of the watched word must match the next expected value
  always @(negedge clk) begin
    if (mon_on && rd_data !== mon_last) begin
      chg_t.push_back(cyc);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2-seq unexpected change actual=%h expected=none", rd_data);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        chk("sequence value R2 R3 R4 R5 R6 R7", 32'(rd_data), 32'(e));
        if (exp_q.size() == 0) chk("done with final value R9", 32'(done), 32'd1);
      end
      mon_last = rd_data;
    end
  end

  // bench model of each interface's write program
  task automatic push_seq(input int idx, input logic on);
    logic [19:0] m;
    m = mdl[idx];
    case (idx)
      0, 1: begin exp_q.push_back(20'h1); m = on ? 20'h5 : 20'h0; exp_q.push_back(m); end
      2:    begin exp_q.push_back(20'h1); m = on ? 20'h3 : 20'h0; exp_q.push_back(m); end
      3:    begin m = on ? 20'h1 : 20'h0; exp_q.push_back(m); end
      default: begin
        if (on) begin
          m[19] = 1'b1; exp_q.push_back(m);
          m[0]  = 1'b1; exp_q.push_back(m);
          m[1]  = 1'b0; exp_q.push_back(m);
          m[19] = 1'b0; exp_q.push_back(m);
        end else begin
          m[1] = 1'b1; exp_q.push_back(m);
          m[0] = 1'b0; exp_q.push_back(m);
        end
      end
    endcase
    mdl[idx] = m;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_idx = 3'(i);
      #1;
      chk(req, 32'(rd_data), (i < 5) ? 32'(mdl[i]) : 32'd0);
    end
  endtask

  // idx < 0 marks a request the bench expects to be refused
  task automatic do_req(input logic [7:0] sel, input logic on, input logic [7:0] us,
                        input int idx, input logic [7:0] inject);
    bit seen;
    @(negedge clk);
    mon_on = 1'b0;
    chg_t.delete();
    rd_idx = (idx >= 0) ? 3'(idx) : 3'd0;
    #1;
    mon_last = rd_data;
    if (idx >= 0) begin push_seq(idx, on); mon_on = 1'b1; end
    req_valid = 1'b1; req_sel = sel; req_on = on; settle_us = us;
    @(negedge clk);
    req_valid = 1'b0;
    if (idx < 0) begin
      #1;
      chk("reject err pulse R10", 32'(err), 32'd1);
      chk("reject stays idle R10", 32'(busy), 32'd0);
      @(negedge clk); #1;
      chk("err one cycle R10", 32'(err), 32'd0);
      check_all("reject leaves words R10");
      return;
    end
    if (inject != 0) begin
      #1;
      chk("busy while sequencing R11", 32'(busy), 32'd1);
      req_valid = 1'b1; req_sel = inject; req_on = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(negedge clk); #1;
      if (done) seen = 1;
    end
    chk("done seen R9", 32'(seen), 32'd1);
    chk("busy low at done R9", 32'(busy), 32'd0);
    chk("all writes observed R9", 32'(exp_q.size()), 32'd0);
    @(negedge clk); #1;
    chk("done one cycle R9", 32'(done), 32'd0);
    mon_on = 1'b0;
    if (idx == 4 && on && chg_t.size() == 4)
      chk("settle window length R8", 32'(chg_t[3] - chg_t[2]),
          32'(((us == 0) ? 1 : int'(us)) * CPU + 1));
  endtask

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = (i == 4) ? 20'h2 : 20'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("reset busy R1", 32'(busy), 32'd0);
    chk("reset done R1", 32'(done), 32'd0);
    chk("reset err R1", 32'(err), 32'd0);
    check_all("reset words R1 and empty index R12");

    do_req(8'h01, 1'b1, 8'd0, 0, 8'h00);   // R2 display A on
    do_req(8'h02, 1'b1, 8'd0, 1, 8'h00);   // R2 display B on
    do_req(8'h01, 1'b0, 8'd0, 0, 8'h00);   // R3 display A off
    do_req(8'h04, 1'b1, 8'd0, 2, 8'h00);   // R4 camera on
    do_req(8'h04, 1'b0, 8'd0, 2, 8'h00);   // R4 camera off
    do_req(8'h08, 1'b1, 8'd0, 3, 8'h00);   // R5 USB on
    do_req(8'h08, 1'b0, 8'd0, 3, 8'h00);   // R5 USB off
    do_req(8'h10, 1'b1, 8'd3, 4, 8'h00);   // R6 R8 HDMI on, 3 us
    do_req(8'h10, 1'b0, 8'd0, 4, 8'h00);   // R7 HDMI off
    do_req(8'h10, 1'b1, 8'd0, 4, 8'h00);   // R8 zero window clamps to 1 us
    do_req(8'h00, 1'b1, 8'd0, -1, 8'h00);  // R10 empty select
    do_req(8'h06, 1'b1, 8'd0, -1, 8'h00);  // R10 two bits
    do_req(8'h20, 1'b1, 8'd0, -1, 8'h00);  // R10 undefined interface
    do_req(8'h04, 1'b1, 8'd0, 2, 8'h08);   // R11 USB request while busy
    check_all("busy request ignored R11 and final words");
    finish_run();
  end
endmodule